// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Scheduler

This block keeps an asynchronous DRAM alive. After reset it waits out a fixed settling pause. It then runs a burst of CAS-before-RAS refresh cycles, and only after that burst does it declare the memory usable. From then on a free-running interval timer adds one owed refresh per period. Each owed refresh raises a request towards an arbiter that the block shares with the host access sequencer.

When the arbiter grants, the block takes over the row strobe, both column strobes, the write strobe and the output enable for one refresh cycle. In that cycle the column strobes fall first and the row strobe follows. The write strobe and output enable stay high, so the data pins remain undriven. The block holds busy until the row-precharge time has elapsed.

Owed refreshes that the arbiter cannot serve at once are counted in a small debt register and served later, back to back. The host side must keep off the memory until the init-done flag is high. That flag is set only after the precharge of the last initialisation refresh.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and just after it, req_o, busy_o and init_done_o are low, and ras_n_o, lcas_n_o, ucas_n_o, we_n_o and oe_n_o are all high.
- R2: The first request appears exactly PAUSE_CYC clock edges after reset is released. No strobe moves before that.
- R3: In every refresh cycle both column strobes fall together. They fall T_CSR_CYC cycles before the row strobe falls, after T_SETUP_CYC cycles in which every strobe is high. The two column strobes are always equal.
- R4: The row strobe stays low for exactly T_RAS_CYC cycles. It then stays high for T_RP_CYC cycles of precharge, and busy_o stays high through the precharge. A cycle therefore lasts T_SETUP_CYC+T_CSR_CYC+T_RAS_CYC+T_RP_CYC cycles after the grant edge.
- R5: we_n_o and oe_n_o are high in every cycle, so the write strobe is high around the row fall and the data outputs stay high-impedance.
- R6: After the pause, exactly INIT_CNT refresh cycles run before init_done_o goes high. init_done_o rises in the same cycle that busy_o falls after the last of these cycles, and it never falls again.
- R7: After initialisation the interval timer adds one owed refresh every INTERVAL_CYC cycles. The first request appears INTERVAL_CYC cycles after init_done_o rises, and later owed refreshes follow at the same period.
- R8: Owed refreshes that are not granted accumulate, up to 2^DEBT_W-1 of them. Each one is later served by its own refresh cycle, and the request drops once all are served.
- R9: A refresh cycle starts on a clock edge where req_o and grant_i are both high, and busy_o is high from the next cycle. req_o is low while busy_o is high. grant_i while req_o is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Arbiter grant for the pending refresh |
| req_o | output | 1 | Refresh wanted (initialisation or owed) |
| busy_o | output | 1 | Block owns the DRAM strobes |
| init_done_o | output | 1 | Power-up sequence complete; host traffic allowed |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| we_n_o | output | 1 | Write strobe, held high |
| oe_n_o | output | 1 | Output enable, held high |

## Verification
The bench times the pause edge by edge. A pause counter that is off by one would let the request rise a cycle early or late. The bench checks every strobe in every cycle of each refresh. A row strobe that falls with or before the column strobes, or a precharge cut short while busy drops, shows up as a strobe mismatch. Over the initialisation burst it counts refreshes and watches the exact cycle where init-done rises, so a design that ends the burst one refresh early or flags readiness before the precharge is caught. It then withholds the grant across three timer periods and expects exactly three back-to-back refreshes, followed by a grant that nothing answers. A design that drops deferred refreshes, or that starts a cycle on a bare grant, fails this test. The next periodic request must land on the exact interval edge.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [2:0] {
    CBR_IDLE,
    CBR_SETUP,
    CBR_CAS,
    CBR_RAS,
    CBR_PRE
  } cbr_state_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_CYC = 3750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(INTERVAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr #(
  parameter int DEBT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pending_o
);
  localparam logic [DEBT_W-1:0] DMAX = '1;

  logic [DEBT_W-1:0] debt_q;

  assign pending_o = (debt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else if (inc_i && !dec_i && debt_q != DMAX) debt_q <= debt_q + 1'b1;
    else if (dec_i && !inc_i && debt_q != '0)   debt_q <= debt_q - 1'b1;
  end
endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
  import refresh_pkg::*;
#(
  parameter int T_SETUP_CYC = 2,
  parameter int T_CSR_CYC   = 1,
  parameter int T_RAS_CYC   = 8,
  parameter int T_RP_CYC    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int TMAX_A = (T_SETUP_CYC > T_CSR_CYC) ? T_SETUP_CYC : T_CSR_CYC;
  localparam int TMAX_B = (T_RAS_CYC > T_RP_CYC) ? T_RAS_CYC : T_RP_CYC;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int CW     = $clog2(TMAX + 1);

  cbr_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic last;

  assign last    = (cnt_q == '0);
  assign busy_o  = (st_q != CBR_IDLE);
  assign done_o  = (st_q == CBR_PRE) && last;
  assign ras_n_o = (st_q != CBR_RAS);
  assign cas_n_o = !((st_q == CBR_CAS) || (st_q == CBR_RAS));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == CBR_IDLE) begin
      if (start_i) begin
        st_d  = CBR_SETUP;
        cnt_d = CW'(T_SETUP_CYC - 1);
      end
    end else if (!last) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      unique case (st_q)
        CBR_SETUP: begin st_d = CBR_CAS; cnt_d = CW'(T_CSR_CYC - 1); end
        CBR_CAS:   begin st_d = CBR_RAS; cnt_d = CW'(T_RAS_CYC - 1); end
        CBR_RAS:   begin st_d = CBR_PRE; cnt_d = CW'(T_RP_CYC - 1);  end
        default:   begin st_d = CBR_IDLE; cnt_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CBR_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int INTERVAL_CYC = 3750,
  parameter int PAUSE_CYC    = 25000,
  parameter int INIT_CNT     = 8,
  parameter int DEBT_W       = 3,
  parameter int T_SETUP_CYC  = 2,
  parameter int T_CSR_CYC    = 1,
  parameter int T_RAS_CYC    = 8,
  parameter int T_RP_CYC     = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic req_o,
  output logic busy_o,
  output logic init_done_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic we_n_o,
  output logic oe_n_o
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_CNT + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);

  logic [PW-1:0] pause_q;
  logic          pause_done_q;
  logic [IW-1:0] init_left_q;
  logic          init_done_q;
  logic          seq_busy, seq_done, seq_cas_n, start;
  logic          tick, debt_pending;

  assign req_o = !seq_busy &&
                 (init_done_q ? debt_pending : (pause_done_q && init_left_q != '0));
  assign start = req_o && grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q      <= '0;
      pause_done_q <= 1'b0;
    end else if (!pause_done_q) begin
      pause_q <= pause_q + 1'b1;
      if (pause_q == PAUSE_LAST) pause_done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_left_q <= IW'(INIT_CNT);
      init_done_q <= 1'b0;
    end else if (!init_done_q) begin
      if (start) init_left_q <= init_left_q - 1'b1;
      // ready only once the final init cycle has precharged
      if (seq_done && init_left_q == '0) init_done_q <= 1'b1;
    end
  end

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_q),
    .tick_o (tick)
  );

  refresh_debt_ctr #(.DEBT_W(DEBT_W)) u_debt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (tick),
    .dec_i     (start && init_done_q),
    .pending_o (debt_pending)
  );

  cbr_sequencer #(
    .T_SETUP_CYC (T_SETUP_CYC),
    .T_CSR_CYC   (T_CSR_CYC),
    .T_RAS_CYC   (T_RAS_CYC),
    .T_RP_CYC    (T_RP_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (seq_busy),
    .done_o  (seq_done),
    .ras_n_o (ras_n_o),
    .cas_n_o (seq_cas_n)
  );

  assign busy_o      = seq_busy;
  assign init_done_o = init_done_q;
  assign lcas_n_o    = seq_cas_n;
  assign ucas_n_o    = seq_cas_n;
  assign we_n_o      = 1'b1;
  assign oe_n_o      = 1'b1;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int T_RAS_CYC = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic grant_i,
  input logic req_o,
  input logic busy_o,
  input logic init_done_o,
  input logic ras_n_o,
  input logic lcas_n_o,
  input logic ucas_n_o
);
  logic [15:0] ras_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ras_lo_cnt <= '0;
    else if (!ras_n_o) ras_lo_cnt <= (ras_lo_cnt == 16'hffff) ? ras_lo_cnt : ras_lo_cnt + 1'b1;
    else               ras_lo_cnt <= '0;
  end

  p_cas_before_ras_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> !lcas_n_o && $past(!lcas_n_o));

  p_cas_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcas_n_o == ucas_n_o);

  p_ras_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> ras_lo_cnt >= 16'(T_RAS_CYC));

  p_ras_in_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> busy_o);

  p_precharge_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> busy_o);

  p_init_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && grant_i |=> busy_o);

  p_no_req_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_o);
endmodule

bind refresh_sched refresh_sched_chk #(.T_RAS_CYC(T_RAS_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grant_i     (grant_i),
  .req_o       (req_o),
  .busy_o      (busy_o),
  .init_done_o (init_done_o),
  .ras_n_o     (ras_n_o),
  .lcas_n_o    (lcas_n_o),
  .ucas_n_o    (ucas_n_o)
);

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
  localparam int INTERVAL = 100;
  localparam int PAUSE    = 30;
  localparam int INITN    = 8;
  localparam int DEBTW    = 2;
  localparam int CYC_LEN  = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic grant_i = 1'b0;
  logic req_o, busy_o, init_done_o, ras_n_o, lcas_n_o, ucas_n_o, we_n_o, oe_n_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int r0 = 0;
  int e_cyc = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  refresh_sched #(
    .INTERVAL_CYC (INTERVAL),
    .PAUSE_CYC    (PAUSE),
    .INIT_CNT     (INITN),
    .DEBT_W       (DEBTW)
  ) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_i     (grant_i),
    .req_o       (req_o),
    .busy_o      (busy_o),
    .init_done_o (init_done_o),
    .ras_n_o     (ras_n_o),
    .lcas_n_o    (lcas_n_o),
    .ucas_n_o    (ucas_n_o),
    .we_n_o      (we_n_o),
    .oe_n_o      (oe_n_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", rq, cyc, act, exp);
    end
  endtask

  function automatic int strobes();
    return {ras_n_o, lcas_n_o, ucas_n_o, we_n_o, oe_n_o};
  endfunction

  // one granted refresh; sample j counts negedges after the start edge
  task automatic do_cbr(input bit in_init, input bit last_init);
    chk(req_o, "R9 req before grant", req_o, 1);
    grant_i = 1'b1;
    @(negedge clk_i);
    grant_i = 1'b0;
    for (int j = 0; j <= CYC_LEN; j++) begin
      bit e_cas, e_ras;
      if (j > 0) @(negedge clk_i);
      e_cas = !(j >= 2 && j <= 10);
      e_ras = !(j >= 3 && j <= 10);
      chk(busy_o == (j < CYC_LEN), "R4 busy", busy_o, j < CYC_LEN);
      chk(lcas_n_o == e_cas && ucas_n_o == e_cas, "R3 cas", {lcas_n_o, ucas_n_o}, {e_cas, e_cas});
      chk(ras_n_o == e_ras, "R4 ras", ras_n_o, e_ras);
      chk(we_n_o && oe_n_o, "R5 we/oe high", {we_n_o, oe_n_o}, 3);
      if (j < CYC_LEN) chk(!req_o, "R9 req low while busy", req_o, 0);
      if (in_init)
        chk(init_done_o == (last_init && j == CYC_LEN), "R6 init_done timing",
            init_done_o, last_init && j == CYC_LEN);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!req_o && !busy_o && !init_done_o, "R1 reset flags", {req_o, busy_o, init_done_o}, 0);
    chk(strobes() == 31, "R1 reset strobes", strobes(), 31);
    rst_ni = 1'b1;
    r0 = cyc;
  endtask

  task automatic t_pause();
    bit quiet = 1'b1;
    while (!req_o && cyc - r0 < PAUSE + 20) begin
      @(negedge clk_i);
      if (strobes() != 31 || busy_o) quiet = 1'b0;
    end
    chk(cyc - r0 == PAUSE, "R2 pause length", cyc - r0, PAUSE);
    chk(quiet, "R2 no strobe during pause", quiet, 1);
  endtask

  task automatic t_init();
    for (int i = 0; i < INITN; i++) begin
      int w = 0;
      while (!req_o && w < 10) begin @(negedge clk_i); w++; end
      do_cbr(1'b1, i == INITN - 1);
    end
    e_cyc = cyc;
    chk(!req_o, "R6 no ninth init refresh", req_o, 0);
  endtask

  task automatic t_interval_and_debt();
    int falls = 0;
    bit prev_ras = 1'b1;
    bit idle_ok = 1'b1;
    while (cyc < e_cyc + INTERVAL) begin
      chk(!req_o, "R7 no early request", req_o, 0);
      @(negedge clk_i);
    end
    chk(req_o, "R7 first interval request", req_o, 1);
    while (cyc < e_cyc + 3 * INTERVAL + 20) @(negedge clk_i);
    chk(req_o, "R8 debt still pending", req_o, 1);
    grant_i = 1'b1;
    for (int m = 1; m <= 75; m++) begin
      @(negedge clk_i);
      if (prev_ras && !ras_n_o) falls++;
      prev_ras = ras_n_o;
      if (m >= 52 && (busy_o || !ras_n_o || req_o)) idle_ok = 1'b0;
    end
    grant_i = 1'b0;
    chk(falls == 3, "R8 deferred refreshes served", falls, 3);
    chk(idle_ok, "R9 grant without request ignored", idle_ok, 1);
    while (!req_o && cyc < e_cyc + 5 * INTERVAL) @(negedge clk_i);
    chk(cyc == e_cyc + 4 * INTERVAL, "R7 periodic request", cyc - e_cyc, 4 * INTERVAL);
    do_cbr(1'b0, 1'b0);
    chk(init_done_o, "R6 init_done sticky", init_done_o, 1);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_pause();
    t_init();
    t_interval_and_debt();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule